// File: doc/BRIEF.md
# Linked Descriptor Transfer Walker

This block moves a sequence of buffers for a card host controller by following a list of transfer descriptors kept in system memory. Once it is enabled and started, it reads each descriptor one word at a time through a single-word memory port. It checks that the descriptor is handed over to hardware and then issues burst requests that cover the described buffer. Each burst is paced by a valid/ready beat stream, which stands for the card-side data source or sink. When a buffer is finished, the walker writes the control word back with the hand-over bit cleared. It then moves on to the next descriptor, either through an explicit pointer or by stepping to the adjacent slot, and stops after the descriptor flagged as final.

Two descriptor layouts are supported and selected per run. The narrow layout has four words: control at offset 0, size at 4, buffer address at 8 and next pointer at 12. The wide layout has eight words: control at 0, size at 8, buffer address low/high at 16/20 and next pointer low/high at 24/28; the words at 4 and 12 are reserved. In the control word, bit 31 marks the descriptor as owned by hardware, bit 4 selects the explicit next pointer, bit 3 flags the first segment (carried through untouched) and bit 2 flags the final segment. Completion and fault conditions are held in a three-bit write-one-to-clear status vector, which drives a single interrupt line.

Top module: `dsc_chain_walker`

## Requirements
- R1: A start pulse on `go` while `dma_en` is low is ignored: no memory request is issued and the status stays clear.
- R2: Descriptor words are read one request at a time, each read completing before the next is issued, in ascending order from the descriptor address: byte offsets 0, 4, 8, 12 in narrow mode, and 0, 8, 16, 20, 24, 28 in wide mode (the reserved words are skipped).
- R3: If the control word read has bit 31 clear, the walker reads no further word of that descriptor, issues no burst and no write-back, sets status bit 2 (descriptor unavailable) and stops.
- R4: The buffer word count is bits 12:2 of the size word (all other bits are ignored). It is covered by bursts of at most BURST_WORDS words each at consecutive addresses starting at the buffer address, each burst address being the previous one plus 4 times its length. `bst_wr` equals the run's `dir_rx`.
- R5: Each burst completes after exactly `bst_len` accepted beats (`beat_valid` and `beat_ready` both high), and `beat_last` is high on exactly the final beat of each burst.
- R6: After the buffer completes, exactly one word is written to the descriptor address. It holds the control word with bit 31 cleared and every other bit unchanged.
- R7: The next descriptor address is the descriptor's next pointer when control bit 4 is set. Otherwise it is the current address plus 16 (narrow) or 32 (wide).
- R8: After the write-back of a descriptor with control bit 2 set, the walker stops and sets status bit 0 if `dir_rx` was 1, or status bit 1 otherwise.
- R9: Ones written on `stat_clr` clear the matching status bits and leave the others unchanged. `irq` is high exactly when any status bit is set.
- R10: A descriptor whose word count is zero issues no burst, but its write-back and chain step still happen.
- R11: While reset is held, `mreq`, `bst_req` and `beat_ready` are low, and `stat` and `irq` are zero.
- R12: In wide mode, the high words of the buffer address and the next pointer form bits 63:32 of those addresses. In narrow mode, those bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_en | input | 1 | Transfer enable; must be high for `go` to take effect |
| go | input | 1 | Start pulse, honoured only while idle |
| mode_wide | input | 1 | Descriptor layout: 1 = eight-word wide, 0 = four-word narrow |
| dir_rx | input | 1 | Direction: 1 = receive (card to memory), 0 = transmit |
| desc_base | input | ADDR_W | Address of the first descriptor |
| mreq | output | 1 | Single-word memory request |
| mwe | output | 1 | Memory request is a write |
| maddr | output | ADDR_W | Memory word byte address |
| mwdata | output | 32 | Write data (control word write-back) |
| mgnt | input | 1 | Memory request accepted |
| mrvalid | input | 1 | Read data valid |
| mrdata | input | 32 | Read data |
| bst_req | output | 1 | Buffer burst request |
| bst_wr | output | 1 | Burst writes memory (receive direction) |
| bst_addr | output | ADDR_W | Burst start byte address |
| bst_len | output | LEN_W | Burst length in words |
| bst_gnt | input | 1 | Burst request accepted |
| beat_valid | input | 1 | Beat stream valid |
| beat_ready | output | 1 | Walker accepts a beat |
| beat_last | output | 1 | Current beat is the final one of its burst |
| stat_clr | input | 3 | Write-one-to-clear status strobe |
| stat | output | 3 | Status: bit 0 receive done, bit 1 transmit done, bit 2 descriptor unavailable |
| irq | output | 1 | Interrupt, high while any status bit is set |

## Verification
The hardest situation to reach is a hand-over failure in the middle of a chain. The walker has to finish earlier descriptors completely, then read exactly one control word of the refused descriptor and nothing more. The bench builds chains in a memory model where a chosen descriptor has its ownership bit cleared, at position 0 and at a later position, in both layouts. It then compares every memory read, burst and write-back in order against a list it computes from the descriptor contents. The grant, read-return and beat handshakes follow a pseudo-random pattern, so request holding and multi-burst buffers (0, 3, 9 and 17 words) are exercised with stalls on every interface.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

  // control word flag positions (software-visible, decoded by the walker)
  localparam int unsigned OWN_BIT   = 31;
  localparam int unsigned CHAIN_BIT = 4;
  localparam int unsigned LAST_BIT  = 2;
  localparam logic [31:0] OWN_MASK  = 32'(1) << OWN_BIT;

  // status bit positions
  localparam int unsigned ST_RX = 0;
  localparam int unsigned ST_TX = 1;
  localparam int unsigned ST_NA = 2;
  localparam int unsigned ST_W  = 3;

  typedef enum logic [2:0] {
    W_IDLE,
    W_RD,
    W_RDW,
    W_XFER,
    W_WB
  } walk_st_e;

  typedef enum logic [1:0] {
    B_IDLE,
    B_REQ,
    B_BEAT
  } bst_st_e;

  // next word slot to fetch; the wide layout skips the reserved slots 1 and 3
  function automatic logic [2:0] nxt_slot(input logic wide, input logic [2:0] slot);
    if (wide && (slot == 3'd0 || slot == 3'd2)) return slot + 3'd2;
    return slot + 3'd1;
  endfunction

  function automatic logic [2:0] end_slot(input logic wide);
    return wide ? 3'd7 : 3'd3;
  endfunction

endpackage

// File: rtl/dcw_desc_regs.sv
module dcw_desc_regs #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned SIZE_W = 13,
  localparam int unsigned CNT_W = SIZE_W - 2,
  localparam int unsigned HI_W  = ADDR_W - 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              wide,
  input  logic [2:0]        slot,
  input  logic [31:0]       word,
  output logic [31:0]       ctrl,
  output logic [CNT_W-1:0]  n_words,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [ADDR_W-1:0] nxt_addr
);

  logic [31:0]       ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] buf_q, buf_d;
  logic [ADDR_W-1:0] nxt_q, nxt_d;

  always_comb begin
    ctrl_d = ctrl_q;
    cnt_d  = cnt_q;
    buf_d  = buf_q;
    nxt_d  = nxt_q;
    if (cap_en) begin
      if (!wide) begin
        unique case (slot)
          3'd0: ctrl_d = word;
          3'd1: cnt_d  = word[SIZE_W-1:2];
          3'd2: buf_d  = {{HI_W{1'b0}}, word};
          3'd3: nxt_d  = {{HI_W{1'b0}}, word};
          default: ;
        endcase
      end else begin
        unique case (slot)
          3'd0: ctrl_d = word;
          3'd2: cnt_d  = word[SIZE_W-1:2];
          3'd4: buf_d[31:0] = word;
          3'd5: buf_d[ADDR_W-1:32] = word[HI_W-1:0];
          3'd6: nxt_d[31:0] = word;
          3'd7: nxt_d[ADDR_W-1:32] = word[HI_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      buf_q  <= '0;
      nxt_q  <= '0;
    end else if (cap_en) begin
      ctrl_q <= ctrl_d;
      cnt_q  <= cnt_d;
      buf_q  <= buf_d;
      nxt_q  <= nxt_d;
    end
  end

  assign ctrl     = ctrl_q;
  assign n_words  = cnt_q;
  assign buf_addr = buf_q;
  assign nxt_addr = nxt_q;

endmodule

// File: rtl/dcw_burst_gen.sv
module dcw_burst_gen
  import dcw_pkg::*;
#(
  parameter int unsigned ADDR_W      = 64,
  parameter int unsigned CNT_W       = 11,
  parameter int unsigned BURST_WORDS = 8,
  localparam int unsigned LEN_W      = $clog2(BURST_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  start_words,
  output logic              bst_req,
  output logic [ADDR_W-1:0] bst_addr,
  output logic [LEN_W-1:0]  bst_len,
  input  logic              bst_gnt,
  input  logic              beat_valid,
  output logic              beat_ready,
  output logic              beat_last,
  output logic              done
);

  bst_st_e           st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [LEN_W-1:0]  beat_q, beat_d;
  logic              done_q, done_d;
  logic [LEN_W-1:0]  len_now;

  assign len_now = (rem_q > CNT_W'(BURST_WORDS)) ? LEN_W'(BURST_WORDS) : LEN_W'(rem_q);

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    rem_d  = rem_q;
    beat_d = beat_q;
    done_d = 1'b0;
    unique case (st_q)
      B_IDLE: begin
        if (start) begin
          addr_d = start_addr;
          rem_d  = start_words;
          if (start_words == '0) done_d = 1'b1;
          else                   st_d   = B_REQ;
        end
      end
      B_REQ: begin
        if (bst_gnt) begin
          beat_d = len_now;
          st_d   = B_BEAT;
        end
      end
      B_BEAT: begin
        if (beat_valid) begin
          beat_d = beat_q - LEN_W'(1);
          if (beat_q == LEN_W'(1)) begin
            rem_d  = rem_q - CNT_W'(len_now);
            addr_d = addr_q + (ADDR_W'(len_now) << 2);
            if (rem_q == CNT_W'(len_now)) begin
              done_d = 1'b1;
              st_d   = B_IDLE;
            end else begin
              st_d   = B_REQ;
            end
          end
        end
      end
      default: st_d = B_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= B_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
      beat_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      rem_q  <= rem_d;
      beat_q <= beat_d;
      done_q <= done_d;
    end
  end

  assign bst_req    = (st_q == B_REQ);
  assign bst_addr   = addr_q;
  assign bst_len    = len_now;
  assign beat_ready = (st_q == B_BEAT);
  assign beat_last  = (st_q == B_BEAT) && (beat_q == LEN_W'(1));
  assign done       = done_q;

endmodule

// File: rtl/dcw_status.sv
module dcw_status
  import dcw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] set,
  input  logic [ST_W-1:0] clr,
  output logic [ST_W-1:0] stat,
  output logic            irq
);

  logic [ST_W-1:0] stat_q, stat_d;
  logic            upd;

  assign upd    = (|set) || (|clr);
  assign stat_d = (stat_q & ~clr) | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stat_q <= '0;
    else if (upd) stat_q <= stat_d;
  end

  assign stat = stat_q;
  assign irq  = |stat_q;

endmodule

// File: rtl/dsc_chain_walker.sv
module dsc_chain_walker
  import dcw_pkg::*;
#(
  parameter int unsigned ADDR_W      = 64,
  parameter int unsigned SIZE_W      = 13,
  parameter int unsigned BURST_WORDS = 8,
  localparam int unsigned LEN_W      = $clog2(BURST_WORDS + 1),
  localparam int unsigned CNT_W      = SIZE_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_en,
  input  logic              go,
  input  logic              mode_wide,
  input  logic              dir_rx,
  input  logic [ADDR_W-1:0] desc_base,
  output logic              mreq,
  output logic              mwe,
  output logic [ADDR_W-1:0] maddr,
  output logic [31:0]       mwdata,
  input  logic              mgnt,
  input  logic              mrvalid,
  input  logic [31:0]       mrdata,
  output logic              bst_req,
  output logic              bst_wr,
  output logic [ADDR_W-1:0] bst_addr,
  output logic [LEN_W-1:0]  bst_len,
  input  logic              bst_gnt,
  input  logic              beat_valid,
  output logic              beat_ready,
  output logic              beat_last,
  input  logic [ST_W-1:0]   stat_clr,
  output logic [ST_W-1:0]   stat,
  output logic              irq
);

  walk_st_e          st_q, st_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic [2:0]        slot_q, slot_d;
  logic              wide_q, wide_d;
  logic              rx_q, rx_d;
  logic              run_en;

  logic              cap_en;
  logic [31:0]       ctrl_w;
  logic [CNT_W-1:0]  words_w;
  logic [ADDR_W-1:0] buf_w;
  logic [ADDR_W-1:0] nxt_w;
  logic              bst_start;
  logic              bst_done;
  logic [ST_W-1:0]   stat_set;
  logic [ADDR_W-1:0] stride;

  assign cap_en = (st_q == W_RDW) && mrvalid;
  assign stride = wide_q ? ADDR_W'(32) : ADDR_W'(16);

  dcw_desc_regs #(
    .ADDR_W (ADDR_W),
    .SIZE_W (SIZE_W)
  ) u_desc (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .wide     (wide_q),
    .slot     (slot_q),
    .word     (mrdata),
    .ctrl     (ctrl_w),
    .n_words  (words_w),
    .buf_addr (buf_w),
    .nxt_addr (nxt_w)
  );

  dcw_burst_gen #(
    .ADDR_W      (ADDR_W),
    .CNT_W       (CNT_W),
    .BURST_WORDS (BURST_WORDS)
  ) u_bst (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (bst_start),
    .start_addr  (buf_w),
    .start_words (words_w),
    .bst_req     (bst_req),
    .bst_addr    (bst_addr),
    .bst_len     (bst_len),
    .bst_gnt     (bst_gnt),
    .beat_valid  (beat_valid),
    .beat_ready  (beat_ready),
    .beat_last   (beat_last),
    .done        (bst_done)
  );

  dcw_status u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (stat_set),
    .clr   (stat_clr),
    .stat  (stat),
    .irq   (irq)
  );

  // walk sequencer: next-state logic
  always_comb begin
    st_d      = st_q;
    cur_d     = cur_q;
    slot_d    = slot_q;
    wide_d    = wide_q;
    rx_d      = rx_q;
    stat_set  = '0;
    bst_start = 1'b0;
    mreq      = 1'b0;
    mwe       = 1'b0;
    maddr     = cur_q + (ADDR_W'(slot_q) << 2);
    mwdata    = ctrl_w & ~OWN_MASK;
    unique case (st_q)
      W_IDLE: begin
        if (go && dma_en) begin
          cur_d  = desc_base;
          slot_d = 3'd0;
          wide_d = mode_wide;
          rx_d   = dir_rx;
          st_d   = W_RD;
        end
      end
      W_RD: begin
        mreq = 1'b1;
        if (mgnt) st_d = W_RDW;
      end
      W_RDW: begin
        if (mrvalid) begin
          if (slot_q == 3'd0 && !mrdata[OWN_BIT]) begin
            stat_set[ST_NA] = 1'b1;
            st_d            = W_IDLE;
          end else if (slot_q == end_slot(wide_q)) begin
            // buffer fields sit in earlier slots, so they are already held
            bst_start = 1'b1;
            st_d      = W_XFER;
          end else begin
            slot_d = nxt_slot(wide_q, slot_q);
            st_d   = W_RD;
          end
        end
      end
      W_XFER: begin
        if (bst_done) st_d = W_WB;
      end
      W_WB: begin
        mreq  = 1'b1;
        mwe   = 1'b1;
        maddr = cur_q;
        if (mgnt) begin
          if (ctrl_w[LAST_BIT]) begin
            stat_set[ST_RX] = rx_q;
            stat_set[ST_TX] = !rx_q;
            st_d            = W_IDLE;
          end else begin
            cur_d  = ctrl_w[CHAIN_BIT] ? nxt_w : (cur_q + stride);
            slot_d = 3'd0;
            st_d   = W_RD;
          end
        end
      end
      default: st_d = W_IDLE;
    endcase
  end

  assign run_en = (st_q == W_IDLE) && go && dma_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= W_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      slot_q <= '0;
    end else if (st_q != W_IDLE || run_en) begin
      cur_q  <= cur_d;
      slot_q <= slot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q <= 1'b0;
      rx_q   <= 1'b0;
    end else if (run_en) begin
      wide_q <= wide_d;
      rx_q   <= rx_d;
    end
  end

  assign bst_wr = rx_q;

endmodule

// File: rtl/dcw_walker_chk.sv
module dcw_walker_chk #(
  parameter int unsigned ADDR_W      = 64,
  parameter int unsigned BURST_WORDS = 8,
  localparam int unsigned LEN_W      = $clog2(BURST_WORDS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mreq,
  input logic              mwe,
  input logic [ADDR_W-1:0] maddr,
  input logic              wb_own,
  input logic              mgnt,
  input logic              mrvalid,
  input logic              rd_own,
  input logic              bst_req,
  input logic [ADDR_W-1:0] bst_addr,
  input logic [LEN_W-1:0]  bst_len,
  input logic              bst_gnt,
  input logic              beat_ready,
  input logic              beat_last,
  input logic [2:0]        stat
);

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq && !mgnt) |=> (mreq && $stable(maddr) && $stable(mwe)));

  p_wb_own_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq && mwe) |-> !wb_own);

  p_bst_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bst_req |-> (bst_len != '0 && bst_len <= LEN_W'(BURST_WORDS)));

  p_bst_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_req && !bst_gnt) |=> (bst_req && $stable(bst_addr) && $stable(bst_len)));

  p_last_in_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_ready);

  p_rx_after_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[0]) |-> $past(mreq && mwe && mgnt));

  p_tx_after_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[1]) |-> $past(mreq && mwe && mgnt));

  p_na_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[2]) |-> $past(mrvalid && !rd_own));

endmodule

bind dsc_chain_walker dcw_walker_chk #(
  .ADDR_W      (ADDR_W),
  .BURST_WORDS (BURST_WORDS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mreq       (mreq),
  .mwe        (mwe),
  .maddr      (maddr),
  .wb_own     (mwdata[31]),
  .mgnt       (mgnt),
  .mrvalid    (mrvalid),
  .rd_own     (mrdata[31]),
  .bst_req    (bst_req),
  .bst_addr   (bst_addr),
  .bst_len    (bst_len),
  .bst_gnt    (bst_gnt),
  .beat_ready (beat_ready),
  .beat_last  (beat_last),
  .stat       (stat)
);

// File: tb/dsc_chain_walker_tb.sv
module dsc_chain_walker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dma_en = 1'b0;
  logic        go = 1'b0;
  logic        mode_wide = 1'b0;
  logic        dir_rx = 1'b0;
  logic [63:0] desc_base = '0;
  logic        mreq, mwe;
  logic [63:0] maddr;
  logic [31:0] mwdata;
  logic        mgnt = 1'b0;
  logic        mrvalid = 1'b0;
  logic [31:0] mrdata = '0;
  logic        bst_req, bst_wr;
  logic [63:0] bst_addr;
  logic [3:0]  bst_len;
  logic        bst_gnt = 1'b0;
  logic        beat_valid = 1'b0;
  logic        beat_ready, beat_last;
  logic [2:0]  stat_clr = '0;
  logic [2:0]  stat;
  logic        irq;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dsc_chain_walker u_dut (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .go(go), .mode_wide(mode_wide),
    .dir_rx(dir_rx), .desc_base(desc_base), .mreq(mreq), .mwe(mwe), .maddr(maddr),
    .mwdata(mwdata), .mgnt(mgnt), .mrvalid(mrvalid), .mrdata(mrdata),
    .bst_req(bst_req), .bst_wr(bst_wr), .bst_addr(bst_addr), .bst_len(bst_len),
    .bst_gnt(bst_gnt), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_last(beat_last), .stat_clr(stat_clr), .stat(stat), .irq(irq)
  );

  int n_vec = 0;
  int n_bad = 0;

  logic [31:0] mem [0:1023];
  logic [63:0] e_rd [0:63];
  logic [63:0] e_ba [0:63];
  int          e_bl [0:63];
  logic [63:0] e_wa [0:15];
  logic [31:0] e_wd [0:15];
  int e_rd_n, e_bst_n, e_wb_n, e_beats;
  logic [2:0] e_stat;
  logic       e_dir;
  int o_rd, o_bst, o_wb, o_beats, cur_len, beat_in, mreq_seen;
  logic        rd_pend = 1'b0;
  logic [63:0] pend_a = '0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // memory, burst and beat responder: acts at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mgnt    = 1'b0;
      bst_gnt = 1'b0;
      mrvalid = 1'b0;
      beat_valid = 1'b0;
      if (rst_n) begin
        if (rd_pend && lfsr[1]) begin
          mrvalid = 1'b1;
          mrdata  = mem[pend_a[11:2]];
          rd_pend = 1'b0;
        end
        if (mreq) mreq_seen++;
        if (mreq && lfsr[0]) begin
          mgnt = 1'b1;
          if (!mwe) begin
            chk(o_rd < e_rd_n && maddr == e_rd[o_rd & 63], "R2 R7 descriptor read address",
                maddr, e_rd[o_rd & 63]);
            o_rd++;
            rd_pend = 1'b1;
            pend_a  = maddr;
          end else begin
            chk(o_wb < e_wb_n && maddr == e_wa[o_wb & 15], "R6 write-back address",
                maddr, e_wa[o_wb & 15]);
            chk(mwdata == e_wd[o_wb & 15], "R6 write-back data", 64'(mwdata), 64'(e_wd[o_wb & 15]));
            mem[maddr[11:2]] = mwdata;
            o_wb++;
          end
        end
        if (bst_req && lfsr[2]) begin
          bst_gnt = 1'b1;
          chk(o_bst < e_bst_n && bst_addr == e_ba[o_bst & 63], "R4 R12 burst address",
              bst_addr, e_ba[o_bst & 63]);
          chk(int'(bst_len) == e_bl[o_bst & 63], "R4 burst length", 64'(bst_len), 64'(e_bl[o_bst & 63]));
          chk(bst_wr == e_dir, "R4 burst direction", 64'(bst_wr), 64'(e_dir));
          cur_len = int'(bst_len);
          beat_in = 0;
          o_bst++;
        end
        beat_valid = lfsr[3] | lfsr[4];
        if (beat_valid && beat_ready) begin
          chk(beat_last == (beat_in == cur_len - 1), "R5 final-beat flag",
              64'(beat_last), 64'(beat_in == cur_len - 1));
          beat_in++;
          o_beats++;
        end
      end
    end
  end

  // global watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL R8 watchdog: actual running expected finished");
    summary();
    $finish;
  end

  task automatic run_chain(input int mode, input int dir, input int n, input int chained, input int na_at);
    logic [63:0] a [0:3];
    int words_tab [0:3];
    int stride, t;
    words_tab[0] = 9; words_tab[1] = 0; words_tab[2] = 17; words_tab[3] = 3;
    stride = (mode != 0) ? 32 : 16;
    e_rd_n = 0; e_bst_n = 0; e_wb_n = 0; e_beats = 0; e_stat = '0;
    e_dir = (dir != 0);
    for (int k = 0; k < 4; k++)
      a[k] = (chained != 0) ? 64'(32'h100 + ((k * 3) % 4) * 32'h40) : 64'(32'h100 + k * stride);
    for (int k = 0; k < n; k++) begin
      logic [31:0] ctrl, szw, bufl, bufh, nxt;
      int w, base_i;
      logic [63:0] ba;
      int rem;
      w    = words_tab[(k + n + mode + dir) % 4];
      ctrl = ((k == na_at) ? 32'h0 : 32'h8000_0000) | ((k == n - 1) ? 32'h4 : 32'h0) |
             ((chained != 0) ? 32'h10 : 32'h0) | ((k == 0) ? 32'h8 : 32'h0) |
             (32'(k + 1) << 8) | 32'h0050_0000;
      szw  = 32'hA000_0000 | 32'(w * 4 + 3);
      bufl = 32'h2000_0000 + 32'(k) * 32'h1000;
      bufh = (mode != 0) ? 32'h0000_0A00 + 32'(k) : 32'h0;
      nxt  = (chained != 0) ? a[k + 1][31:0] : 32'h0000_0FF0;
      base_i = int'(a[k][11:2]);
      if (mode == 0) begin
        mem[base_i] = ctrl; mem[base_i + 1] = szw; mem[base_i + 2] = bufl; mem[base_i + 3] = nxt;
      end else begin
        mem[base_i] = ctrl; mem[base_i + 1] = 32'hDEAD_0001; mem[base_i + 2] = szw;
        mem[base_i + 3] = 32'hDEAD_0003; mem[base_i + 4] = bufl; mem[base_i + 5] = bufh;
        mem[base_i + 6] = nxt; mem[base_i + 7] = 32'h0;
      end
      if (na_at >= 0 && k > na_at) continue;
      e_rd[e_rd_n] = a[k]; e_rd_n++;
      if (k == na_at) begin
        e_stat = 3'b100;
        continue;
      end
      if (mode == 0) begin
        for (int o = 1; o < 4; o++) begin e_rd[e_rd_n] = a[k] + 64'(o * 4); e_rd_n++; end
      end else begin
        for (int o = 2; o < 8; o++) begin
          if (o == 3) continue;
          e_rd[e_rd_n] = a[k] + 64'(o * 4); e_rd_n++;
        end
      end
      ba  = {bufh, bufl};
      rem = w;
      while (rem > 0) begin
        int l;
        l = (rem > BW) ? BW : rem;
        e_ba[e_bst_n] = ba; e_bl[e_bst_n] = l; e_bst_n++;
        ba  = ba + 64'(l * 4);
        rem = rem - l;
      end
      e_beats += w;
      e_wa[e_wb_n] = a[k]; e_wd[e_wb_n] = ctrl & 32'h7FFF_FFFF; e_wb_n++;
      if (k == n - 1) e_stat = (dir != 0) ? 3'b001 : 3'b010;
    end

    @(negedge clk);
    o_rd = 0; o_bst = 0; o_wb = 0; o_beats = 0;
    desc_base = a[0];
    mode_wide = (mode != 0);
    dir_rx    = (dir != 0);
    go        = 1'b1;
    @(negedge clk);
    go = 1'b0;
    mode_wide = ~mode_wide;
    dir_rx    = ~dir_rx;
    t = 0;
    while (!irq && t < 5000) begin @(negedge clk); t++; end
    chk(irq == 1'b1, "R8 R3 run completes", 64'(irq), 64'd1);
    repeat (2) @(negedge clk);
    chk(stat == e_stat, "R8 R3 final status", 64'(stat), 64'(e_stat));
    chk(o_rd == e_rd_n, "R2 R3 read count", 64'(o_rd), 64'(e_rd_n));
    chk(o_bst == e_bst_n, "R4 R10 burst count", 64'(o_bst), 64'(e_bst_n));
    chk(o_wb == e_wb_n, "R6 R3 write-back count", 64'(o_wb), 64'(e_wb_n));
    chk(o_beats == e_beats, "R5 beat count", 64'(o_beats), 64'(e_beats));
    stat_clr = ~e_stat;
    @(negedge clk);
    stat_clr = '0;
    chk(stat == e_stat && irq == 1'b1, "R9 unrelated clear keeps bits", 64'({irq, stat}), 64'({1'b1, e_stat}));
    stat_clr = e_stat;
    @(negedge clk);
    stat_clr = '0;
    chk(stat == 3'b000 && irq == 1'b0, "R9 write-one clear", 64'({irq, stat}), 64'd0);
  endtask

  initial begin
    int seen0;
    repeat (3) @(negedge clk);
    chk(!mreq && !bst_req && !beat_ready, "R11 reset request lines", 64'({mreq, bst_req, beat_ready}), 64'd0);
    chk(stat == 3'b000 && !irq, "R11 reset status", 64'({irq, stat}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: start with the enable low
    seen0 = mreq_seen;
    desc_base = 64'h100;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    repeat (30) @(negedge clk);
    chk(mreq_seen == seen0 && stat == 3'b000, "R1 start ignored while disabled",
        64'(mreq_seen - seen0), 64'd0);

    dma_en = 1'b1;
    for (int mode = 0; mode < 2; mode++)
      for (int dir = 0; dir < 2; dir++)
        for (int ch = 0; ch < 2; ch++)
          for (int n = 1; n <= 3; n++)
            run_chain(mode, dir, n, ch, -1);
    for (int mode = 0; mode < 2; mode++) begin
      run_chain(mode, 1, 3, 1, 1);
      run_chain(mode, 0, 3, 0, 0);
      run_chain(mode, 1, 3, 0, 2);
    end

    summary();
    $finish;
  end

endmodule